// File: doc/BRIEF.md
# Serial Frequency Table Programmer

This block keeps a small table of synthesizer settings: sixteen pixel-clock entries and four memory-clock entries. Each entry holds an 8-bit feedback code, an external-source flag and a 2-bit post-divider code. The table is loaded and inspected over a two-wire serial link. One wire carries a data bit. A 0-to-1 transition on the other wire, the strobe, shifts that bit in. Both wires are asynchronous to the system clock. They pass through a synchronizer, and the strobe is edge-detected in the clock domain.

A frame is twenty bits long and is sent in this order:

- a start bit of 0
- a direction bit (0 = store, 1 = fetch)
- a 5-bit location
- the 11 entry bits
- two stop bits of 1

Every field is sent least significant bit first. If the strobe stays quiet for a programmable number of clocks, the partial frame is dropped and framing starts again at the start bit. Frames may also follow one another directly. A fetch frame loads the addressed entry into an output shifter. The entry's eleven bits then leave one per further strobe rise.

Two registered lookup ports show the current pixel and memory entries to the clock logic that uses them.

Top module: `freq_table_prog`

## Requirements
- R1: After reset the output-enable `rd_oe_o` is 0. Pixel entry i holds feedback code (16*i+3) mod 256, post code i mod 4, and external flag 1 only for i = 6. Memory entry j holds feedback code 32*j+5, post code 2 and flag 0. Entry bit layout: [7:0] feedback, [8] external flag, [10:9] post code. Lookup outputs show the entry selected one clock earlier.
- R2: A frame with start 0, direction 0, a location 0..15 and both stops 1 stores its 11 entry bits into that pixel entry when its 20th strobe rise is seen.
- R3: Location 18 stores memory entry 2 and location 19 stores memory entry 3. Memory entries 0 and 1 keep their reset values.
- R4: Writes to any other location (16, 17, 20..31) change no entry. A fetch of such a location shifts out eleven zeros.
- R5: A frame whose start bit is 1 or whose first or second stop bit is 0 changes no entry. The next frame is framed from its own first bit.
- R6: A valid fetch frame changes no entry and raises `rd_oe_o`. Entry bit k (feedback bit 0 first, then the flag, then the post code LSB first) is on `rd_data_o` after k further strobe rises, for k = 0..10. The 11th further rise drops `rd_oe_o`.
- R7: After the strobe has stayed low or high without a rise for IDLE_CYCLES clocks, a partial frame is discarded and any fetch in progress ends with `rd_oe_o` and `rd_data_o` at 0.
- R8: A frame may follow the previous one with no quiet interval, and both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Asynchronous serial strobe; a rising transition shifts one bit |
| shift_dat_i | input | 1 | Asynchronous serial data bit |
| pix_sel_i | input | $clog2(PIX_N) | Pixel entry lookup index |
| mem_sel_i | input | $clog2(MEM_N) | Memory entry lookup index |
| pix_entry_o | output | 11 | Registered pixel entry at pix_sel_i |
| mem_entry_o | output | 11 | Registered memory entry at mem_sel_i |
| rd_oe_o | output | 1 | High while fetched bits are being shifted out |
| rd_data_o | output | 1 | Current fetched bit |

## Verification
The bench breaks frames in three ways: a start bit of 1, and a 0 in either stop bit. A design that checked only part of the framing would let one of these corrupt an entry. It also writes to the unsupported locations 16 and 25, and to memory locations 18 and 19. A loose location decode would alias these onto pixel entries or onto the fixed memory entries.

Fetches are read bit by bit against a scoreboard queue. An off-by-one in the shift-out order or length shows up as a wrong word, or as `rd_oe_o` still high after the eleventh rise. Partial frames and a half-finished fetch are then followed by a quiet gap. A design without a working timeout would misalign the next frame or keep driving fetched data.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  localparam int FB_W         = 8;
  localparam int POST_W       = 2;
  localparam int ENTRY_W      = FB_W + 1 + POST_W;
  localparam int LOC_W        = 5;
  localparam int FRAME_BITS   = 2 + LOC_W + ENTRY_W + 2;
  localparam int POS_START    = 0;
  localparam int POS_DIR      = 1;
  localparam int POS_LOC      = 2;
  localparam int POS_ENT      = POS_LOC + LOC_W;
  localparam int POS_STOP1    = POS_ENT + ENTRY_W;
  localparam int POS_STOP2    = POS_STOP1 + 1;
  localparam int DEF_PIX_N    = 16;
  localparam int DEF_MEM_N    = 4;
  localparam int DEF_MEM_FIX  = 2;
  localparam int MEM_LOC_BASE = 16;

  typedef struct packed {
    logic [POST_W-1:0] post;
    logic              ext;
    logic [FB_W-1:0]   fb;
  } entry_t;

  function automatic entry_t pix_default(input int unsigned idx);
    entry_t e;
    e.fb   = FB_W'(idx * 16 + 3);
    e.post = POST_W'(idx);
    e.ext  = (idx == 6);
    return e;
  endfunction

  function automatic entry_t mem_default(input int unsigned idx);
    entry_t e;
    e.fb   = FB_W'(idx * 32 + 5);
    e.post = POST_W'(2);
    e.ext  = 1'b0;
    return e;
  endfunction
endpackage

// File: rtl/ftp_sync_edge.sv
module ftp_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      last_q  <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      last_q <= stage_q[STAGES-1];
    end
  end

  assign q_o    = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ftp_frame_ctrl.sv
module ftp_frame_ctrl
  import ftp_pkg::*;
#(
  parameter int IDLE_CYCLES = 6_250_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             bit_i,
  input  entry_t           rb_entry_i,
  output logic             wr_en_o,
  output logic [LOC_W-1:0] loc_o,
  output entry_t           wr_entry_o,
  output logic             idle_hit_o,
  output logic             rb_active_o,
  output logic             rb_bit_o
);
  localparam int CNT_W  = $clog2(IDLE_CYCLES + 1);
  localparam int POS_W  = $clog2(FRAME_BITS);
  localparam int LEFT_W = $clog2(ENTRY_W + 1);

  logic [FRAME_BITS-2:0] sr_q;
  logic [FRAME_BITS-1:0] sr_nxt;
  logic [POS_W-1:0]      pos_q;
  logic [CNT_W-1:0]      idle_q;
  logic                  rb_q;
  logic [LEFT_W-1:0]     left_q;
  logic [ENTRY_W-1:0]    rbsh_q;
  logic                  frame_end, frame_ok, rd_load;

  // newest bit enters at the top; after a full frame bit 0 is the start bit
  assign sr_nxt     = {bit_i, sr_q};
  assign frame_end  = rise_i && !rb_q && (pos_q == POS_W'(FRAME_BITS - 1));
  assign frame_ok   = !sr_nxt[POS_START] && sr_nxt[POS_STOP1] && sr_nxt[POS_STOP2];
  assign loc_o      = sr_nxt[POS_LOC +: LOC_W];
  assign wr_entry_o = entry_t'(sr_nxt[POS_ENT +: ENTRY_W]);
  assign wr_en_o    = frame_end && frame_ok && !sr_nxt[POS_DIR];
  assign rd_load    = frame_end && frame_ok && sr_nxt[POS_DIR];
  assign idle_hit_o = !rise_i && (idle_q == CNT_W'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= CNT_W'(IDLE_CYCLES);
    end else if (rise_i) begin
      idle_q <= '0;
    end else if (idle_q != CNT_W'(IDLE_CYCLES)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || idle_hit_o) begin
      sr_q   <= '0;
      pos_q  <= '0;
      rb_q   <= 1'b0;
      left_q <= '0;
      rbsh_q <= '0;
    end else if (rise_i) begin
      if (rb_q) begin
        rbsh_q <= rbsh_q >> 1;
        left_q <= left_q - 1'b1;
        if (left_q == LEFT_W'(1)) rb_q <= 1'b0;
      end else begin
        sr_q <= sr_nxt[FRAME_BITS-1:1];
        if (frame_end) begin
          pos_q <= '0;
          if (rd_load) begin
            rb_q   <= 1'b1;
            left_q <= LEFT_W'(ENTRY_W);
            rbsh_q <= rb_entry_i;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign rb_active_o = rb_q;
  assign rb_bit_o    = rbsh_q[0];
endmodule

// File: rtl/ftp_entry_table.sv
module ftp_entry_table
  import ftp_pkg::*;
#(
  parameter int PIX_N     = DEF_PIX_N,
  parameter int MEM_N     = DEF_MEM_N,
  parameter int MEM_FIXED = DEF_MEM_FIX,
  localparam int PIX_W    = $clog2(PIX_N),
  localparam int MEM_W    = $clog2(MEM_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [LOC_W-1:0] loc_i,
  input  entry_t           wr_entry_i,
  output entry_t           rd_entry_o,
  input  logic [PIX_W-1:0] pix_sel_i,
  input  logic [MEM_W-1:0] mem_sel_i,
  output entry_t           pix_entry_o,
  output entry_t           mem_entry_o
);
  entry_t pix_q [PIX_N];
  entry_t mem_q [MEM_N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < PIX_N; i++) begin
      if (rst) pix_q[i] <= pix_default(i);
      else if (wr_en_i && loc_i == LOC_W'(i)) pix_q[i] <= wr_entry_i;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < MEM_N; j++) begin
      if (rst) mem_q[j] <= mem_default(j);
      else if (j >= MEM_FIXED && wr_en_i && loc_i == LOC_W'(MEM_LOC_BASE + j))
        mem_q[j] <= wr_entry_i;
    end
  end

  // fetch path: unsupported locations give zero
  always_comb begin
    rd_entry_o = '0;
    if (loc_i < LOC_W'(PIX_N)) rd_entry_o = pix_q[loc_i[PIX_W-1:0]];
    for (int j = MEM_FIXED; j < MEM_N; j++)
      if (loc_i == LOC_W'(MEM_LOC_BASE + j)) rd_entry_o = mem_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_entry_o <= '0;
      mem_entry_o <= '0;
    end else begin
      pix_entry_o <= pix_q[pix_sel_i];
      mem_entry_o <= mem_q[mem_sel_i];
    end
  end
endmodule

// File: rtl/freq_table_prog.sv
module freq_table_prog
  import ftp_pkg::*;
#(
  parameter int PIX_N       = DEF_PIX_N,
  parameter int MEM_N       = DEF_MEM_N,
  parameter int MEM_FIXED   = DEF_MEM_FIX,
  parameter int IDLE_CYCLES = 6_250_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_clk_i,
  input  logic                     shift_dat_i,
  input  logic [$clog2(PIX_N)-1:0] pix_sel_i,
  input  logic [$clog2(MEM_N)-1:0] mem_sel_i,
  output logic [ENTRY_W-1:0]       pix_entry_o,
  output logic [ENTRY_W-1:0]       mem_entry_o,
  output logic                     rd_oe_o,
  output logic                     rd_data_o
);
  logic [1:0]       sync_q, sync_rise;
  logic             strobe_rise, idle_hit, wr_en;
  logic [LOC_W-1:0] loc;
  entry_t           wr_entry, rd_entry, pix_e, mem_e;

  ftp_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({shift_clk_i, shift_dat_i}),
    .q_o(sync_q), .rise_o(sync_rise)
  );

  assign strobe_rise = sync_rise[1];

  ftp_frame_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) u_frame (
    .clk(clk), .rst(rst), .rise_i(strobe_rise), .bit_i(sync_q[0]),
    .rb_entry_i(rd_entry), .wr_en_o(wr_en), .loc_o(loc),
    .wr_entry_o(wr_entry), .idle_hit_o(idle_hit),
    .rb_active_o(rd_oe_o), .rb_bit_o(rd_data_o)
  );

  ftp_entry_table #(.PIX_N(PIX_N), .MEM_N(MEM_N), .MEM_FIXED(MEM_FIXED)) u_table (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .loc_i(loc),
    .wr_entry_i(wr_entry), .rd_entry_o(rd_entry),
    .pix_sel_i(pix_sel_i), .mem_sel_i(mem_sel_i),
    .pix_entry_o(pix_e), .mem_entry_o(mem_e)
  );

  assign pix_entry_o = pix_e;
  assign mem_entry_o = mem_e;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic idle_hit,
  input logic wr_en,
  input logic rd_oe,
  input logic rd_data
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !rd_oe);
  a_r2_write_on_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> rise);
  a_r6_no_write_in_fetch: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_oe);
  a_r6_hold_between_rises: assert property (@(posedge clk) disable iff (rst)
    (rd_oe && !rise && !idle_hit) |=> (rd_oe && $stable(rd_data)));
  a_r6_fetch_starts_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_oe) |-> $past(rise));
  a_r7_timeout_ends_fetch: assert property (@(posedge clk) disable iff (rst)
    idle_hit |=> (!rd_oe && !rd_data));
endmodule

bind freq_table_prog ftp_checker u_chk (
  .clk(clk), .rst(rst), .rise(strobe_rise), .idle_hit(idle_hit),
  .wr_en(wr_en), .rd_oe(rd_oe_o), .rd_data(rd_data_o)
);

// File: tb/tb_freq_table_prog.sv
module tb_freq_table_prog;
  localparam int IDLE = 50;
  logic clk = 0, rst = 1;
  logic sclk = 0, sdat = 0;
  logic [3:0] pix_sel = 0;
  logic [1:0] mem_sel = 0;
  logic [10:0] pix_e, mem_e;
  logic oe, rdat;
  int n_chk = 0, n_fail = 0;
  logic [10:0] pix_m [16];
  logic [10:0] mem_m [4];
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  freq_table_prog #(.IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst(rst), .shift_clk_i(sclk), .shift_dat_i(sdat),
    .pix_sel_i(pix_sel), .mem_sel_i(mem_sel), .pix_entry_o(pix_e),
    .mem_entry_o(mem_e), .rd_oe_o(oe), .rd_data_o(rdat)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_bit(logic b);
    sdat = b; wait_clk(3);
    sclk = 1; wait_clk(4);
    sclk = 0; wait_clk(4);
  endtask

  task automatic send_frame(logic st, logic dir, logic [4:0] loc, logic [10:0] ent,
                            logic s1, logic s2);
    logic [19:0] f;
    f = {s2, s1, ent, loc, dir, st};
    for (int k = 0; k < 20; k++) strobe_bit(f[k]);
  endtask

  task automatic write_entry(logic [4:0] loc, logic [10:0] ent);
    send_frame(0, 0, loc, ent, 1, 1);
    if (loc < 16) pix_m[loc[3:0]] = ent;
    else if (loc == 18 || loc == 19) mem_m[loc[1:0]] = ent;
  endtask

  task automatic check_tables(string req);
    wait_clk(4);
    for (int i = 0; i < 16; i++) begin
      pix_sel = 4'(i); wait_clk(2);
      check(req, pix_e, pix_m[i]);
    end
    for (int j = 0; j < 4; j++) begin
      mem_sel = 2'(j); wait_clk(2);
      check(req, mem_e, mem_m[j]);
    end
  endtask

  // driver: issue a fetch frame and queue the expected word
  task automatic request_fetch(logic [4:0] loc);
    logic [10:0] e;
    e = 0;
    if (loc < 16) e = pix_m[loc[3:0]];
    else if (loc == 18 || loc == 19) e = mem_m[loc[1:0]];
    exp_q.push_back(e);
    send_frame(0, 1, loc, 11'h5A5, 1, 1);
  endtask

  // monitor: gather the shifted word and compare with the queue head
  task automatic collect_fetch(string req);
    logic [10:0] got, e;
    check({req, " oe high"}, oe, 1);
    got[0] = rdat;
    for (int k = 1; k < 11; k++) begin
      sclk = 1; wait_clk(4); sclk = 0; wait_clk(4);
      check({req, " oe"}, oe, 1);
      got[k] = rdat;
    end
    sclk = 1; wait_clk(4); sclk = 0; wait_clk(4);
    check({req, " oe drop"}, oe, 0);
    e = exp_q.pop_front();
    check({req, " word"}, got, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      pix_m[i] = {2'(i), (i == 6) ? 1'b1 : 1'b0, 8'(i * 16 + 3)};
    for (int j = 0; j < 4; j++)
      mem_m[j] = {2'd2, 1'b0, 8'(j * 32 + 5)};
    wait_clk(5); rst = 0; wait_clk(2);

    check("R1 oe", oe, 0);
    check_tables("R1");

    write_entry(5, 11'h6C1);
    write_entry(15, 11'h1FF);
    write_entry(0, 11'h400);
    check_tables("R2");

    write_entry(18, 11'h2AB);
    write_entry(19, 11'h7FE);
    write_entry(17, 11'h111);   // fixed memory entry location: unsupported
    check_tables("R3");

    write_entry(16, 11'h333);
    write_entry(25, 11'h555);
    check_tables("R4");
    request_fetch(25);
    collect_fetch("R4");

    send_frame(1, 0, 3, 11'h0F0, 1, 1);
    send_frame(0, 0, 3, 11'h0F1, 0, 1);
    send_frame(0, 0, 3, 11'h0F2, 1, 0);
    check_tables("R5");
    write_entry(3, 11'h0F3);
    check_tables("R5 realign");

    request_fetch(5);
    collect_fetch("R6 pix5");
    request_fetch(19);
    collect_fetch("R6 mem3");
    check_tables("R6 unchanged");

    for (int k = 0; k < 7; k++) strobe_bit(k[0]);
    wait_clk(IDLE + 30);
    write_entry(9, 11'h2C9);
    check_tables("R7 partial");
    request_fetch(9);
    void'(exp_q.pop_front());
    sclk = 1; wait_clk(4); sclk = 0; wait_clk(4);
    wait_clk(IDLE + 30);
    check("R7 oe", oe, 0);
    check("R7 data", rdat, 0);

    write_entry(1, 11'h3A1);
    write_entry(2, 11'h4B2);
    request_fetch(1);
    collect_fetch("R8 fetch");
    check_tables("R8");

    summary();
    $finish;
  end
endmodule